// File: doc/BRIEF.md
# N-Cube Routing Node Sink Decoder

Every packet that enters a routing node of a single-stage binary 6-cube arrives on one of eight ports. Port 0 is the local processor, ports 1 to 6 are the six dimension links (dimension port k serves tag bit k-1), and port 7 is the local global-memory module. This decoder works out the port the packet must leave on. It uses three inputs: the arrival port, the travel direction and the 6-bit routing tag. The tag is the processor number XOR the memory module number. The sink depends on those three inputs alone.

A packet heading toward memory walks upward from the port above its source. It skips every dimension port whose tag bit is zero and stops at the first port whose bit is one. If no such bit remains, it falls through to the memory port. A returning packet walks downward from the port below its source in the same way. If no such bit remains, it falls through to the processor port. The scan starts at tag bit `src` when going forward and at bit `src-2` when going back.

The decoder is pure combinational logic with one register stage at the output. The register also holds a length flag: a write packet occupies two bus words and a read packet occupies one. Reset is asynchronous and active low, and its release is synchronised to the clock inside the block.

Top module: `ncube_sink_dec`

## Requirements
- R1: While reset is active, and until the first accepted packet, `out_valid`, `out_sink` and `out_two_word` are all 0.
- R2: A packet presented with `in_valid`=1 on a rising edge appears at the outputs after exactly that edge; `out_valid` is never 1 without a request on the preceding edge.
- R3: Forward packets (`in_fwd`=1) receive `out_sink` = k+1. Here k is the lowest set tag bit with index at or above `in_src`. If no such bit is set, `out_sink` = 7 (memory).
- R4: Backward packets (`in_fwd`=0) receive `out_sink` = k+1. Here k is the highest set tag bit with index at or below `in_src`-2. If no such bit is set, `out_sink` = 0 (processor).
- R5: A backward packet arriving on dimension port 1 always goes to the processor port 0, whatever the tag.
- R6: `out_two_word` equals the `in_write` mark of the accepted packet. A value of 1 means a write that spans two words, and 0 means a one-word read.
- R7: A forward packet from port 7 and a backward packet from port 0 are illegal. They yield `out_valid`=0 on the next cycle.
- R8: In any cycle where `out_valid` is 0, `out_sink` and `out_two_word` keep the values of the last legal packet.
- R9: A valid forward result always names a port above the source, and a valid backward result always names a port below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Packet present this cycle |
| in_fwd | input | 1 | 1 = toward memory, 0 = toward processor |
| in_src | input | 3 | Arrival port code (0 processor, 1-6 dimensions, 7 memory) |
| in_tag | input | 6 | Routing tag |
| in_write | input | 1 | 1 = write packet, 0 = read packet |
| out_valid | output | 1 | Registered result valid |
| out_sink | output | 3 | Registered departure port code |
| out_two_word | output | 1 | Registered length flag |

## Verification
The bench drives every combination of source, direction and tag. This reaches the scans that fall off either end of the tag. A decoder that stopped at the wrong end would send memory-bound packets to the processor or the reverse. The sweep also covers scans that start mid-tag with zeros below the start bit, where a design that ignored the start index would pick a lower dimension than allowed. The source-1 return case and the two illegal source/direction pairs are checked separately, because an off-by-one start index or a missing legality test shows up only there. Idle gaps between packets show whether the sink and length registers wrongly load on cycles with no request.

// File: rtl/ncube_pkg.sv
package ncube_pkg;
  localparam int unsigned DIM_W  = 6;
  localparam int unsigned PORTS  = DIM_W + 2;
  localparam int unsigned PORT_W = $clog2(PORTS);

  typedef enum logic [PORT_W-1:0] {
    PORT_CPU = 3'd0,
    PORT_MEM = 3'd7
  } port_end_e;
endpackage

// File: rtl/ncube_rst_sync.sv
module ncube_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/ncube_fwd_scan.sv
module ncube_fwd_scan #(
  parameter int unsigned DIM = 6,
  parameter int unsigned PW  = 3
) (
  input  logic [PW-1:0]  src,
  input  logic [DIM-1:0] tag,
  output logic [PW-1:0]  sink
);
  logic [DIM-1:0] hit;

  // A tag bit may stop the upward walk only at or above the start index.
  for (genvar j = 0; j < DIM; j++) begin : g_elig
    assign hit[j] = tag[j] && (PW'(j) >= src);
  end

  // Lowest eligible one wins; none falls through to the memory port.
  always_comb begin
    sink = PW'(DIM + 1);
    for (int j = DIM - 1; j >= 0; j--) begin
      if (hit[j]) sink = PW'(j + 1);
    end
  end
endmodule

// File: rtl/ncube_bwd_scan.sv
module ncube_bwd_scan #(
  parameter int unsigned DIM = 6,
  parameter int unsigned PW  = 3
) (
  input  logic [PW-1:0]  src,
  input  logic [DIM-1:0] tag,
  output logic [PW-1:0]  sink
);
  logic [DIM-1:0] hit;

  // A tag bit may stop the downward walk only at or below index src-2.
  for (genvar j = 0; j < DIM; j++) begin : g_elig
    assign hit[j] = tag[j] && (PW'(j + 2) <= src);
  end

  // Highest eligible one wins; none falls through to the processor port.
  always_comb begin
    sink = '0;
    for (int j = 0; j < DIM; j++) begin
      if (hit[j]) sink = PW'(j + 1);
    end
  end
endmodule

// File: rtl/ncube_sink_dec.sv
module ncube_sink_dec #(
  parameter int unsigned DIM = 6,
  localparam int unsigned PW = $clog2(DIM + 2)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           in_fwd,
  input  logic [PW-1:0]  in_src,
  input  logic [DIM-1:0] in_tag,
  input  logic           in_write,
  output logic           out_valid,
  output logic [PW-1:0]  out_sink,
  output logic           out_two_word
);
  localparam logic [PW-1:0] TOP_PORT = PW'(DIM + 1);

  logic          rst_int_n;
  logic [PW-1:0] fwd_sink;
  logic [PW-1:0] bwd_sink;
  logic          legal;
  logic          load_en;
  logic          valid_d, valid_q;
  logic [PW-1:0] sink_d,  sink_q;
  logic          len_d,   len_q;

  ncube_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  ncube_fwd_scan #(.DIM(DIM), .PW(PW)) u_fwd (
    .src  (in_src),
    .tag  (in_tag),
    .sink (fwd_sink)
  );

  ncube_bwd_scan #(.DIM(DIM), .PW(PW)) u_bwd (
    .src  (in_src),
    .tag  (in_tag),
    .sink (bwd_sink)
  );

  // Next-state logic
  always_comb begin
    legal   = in_fwd ? (in_src != TOP_PORT) : (in_src != '0);
    load_en = in_valid && legal;
    valid_d = load_en;
    sink_d  = in_fwd ? fwd_sink : bwd_sink;
    len_d   = in_write;
  end

  // Output register
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      valid_q <= 1'b0;
      sink_q  <= '0;
      len_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (load_en) begin
        sink_q <= sink_d;
        len_q  <= len_d;
      end
    end
  end

  assign out_valid    = valid_q;
  assign out_sink     = sink_q;
  assign out_two_word = len_q;
endmodule

// File: rtl/ncube_sink_dec_chk.sv
module ncube_sink_dec_chk #(
  parameter int unsigned DIM = 6,
  parameter int unsigned PW  = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_fwd,
  input logic [PW-1:0]  in_src,
  input logic [DIM-1:0] in_tag,
  input logic           in_write,
  input logic           out_valid,
  input logic [PW-1:0]  out_sink,
  input logic           out_two_word
);
  // R2
  result_has_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R6
  length_follows_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_two_word == $past(in_write)));

  // R5
  dim1_return_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(in_fwd) && ($past(in_src) == PW'(1))) |-> (out_sink == '0));

  // R7
  illegal_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid) && $past(in_fwd) && ($past(in_src) == PW'(DIM + 1))) |-> !out_valid);

  // R7
  illegal_bwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid) && !$past(in_fwd) && ($past(in_src) == '0)) |-> !out_valid);

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_sink) && $stable(out_two_word)));

  // R9
  fwd_goes_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_fwd)) |-> (out_sink > $past(in_src)));

  // R9
  bwd_goes_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(in_fwd)) |-> (out_sink < $past(in_src)));
endmodule

bind ncube_sink_dec ncube_sink_dec_chk #(.DIM(DIM), .PW(PW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_fwd       (in_fwd),
  .in_src       (in_src),
  .in_tag       (in_tag),
  .in_write     (in_write),
  .out_valid    (out_valid),
  .out_sink     (out_sink),
  .out_two_word (out_two_word)
);

// File: tb/ncube_sink_dec_tb.sv
module ncube_sink_dec_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_fwd = 1'b0;
  logic [2:0] in_src = '0;
  logic [5:0] in_tag = '0;
  logic       in_write = 1'b0;
  logic       out_valid;
  logic [2:0] out_sink;
  logic       out_two_word;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  int    exp_valid = 0;
  int    exp_sink  = 0;
  int    exp_len   = 0;
  string exp_req   = "R1";

  always #5 clk = ~clk;

  ncube_sink_dec u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fwd(in_fwd),
    .in_src(in_src), .in_tag(in_tag), .in_write(in_write),
    .out_valid(out_valid), .out_sink(out_sink), .out_two_word(out_two_word)
  );

  // Walk the tag one port at a time, as the routing rule describes it.
  function automatic int walk(input int fwd, input int src, input int tag);
    int s, b;
    if (fwd != 0) begin
      s = src + 1; b = src;
      while (b < 6 && ((tag >> b) & 1) == 0) begin s++; b++; end
    end else begin
      s = src - 1; b = src - 2;
      while (b >= 0 && ((tag >> b) & 1) == 0) begin s--; b--; end
    end
    return s;
  endfunction

  // Reference model, one register stage.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_valid <= 0; exp_sink <= 0; exp_len <= 0; exp_req <= "R1";
    end else begin
      int legal;
      legal = in_fwd ? (in_src != 7) : (in_src != 0);
      if (!in_valid) begin
        exp_valid <= 0; exp_req <= "R8";
      end else if (legal == 0) begin
        exp_valid <= 0; exp_req <= "R7";
      end else begin
        exp_valid <= 1;
        exp_sink  <= walk(int'(in_fwd), int'(in_src), int'(in_tag));
        exp_len   <= int'(in_write);
        if (!in_fwd && in_src == 1) exp_req <= "R5";
        else exp_req <= in_fwd ? "R3" : "R4";
      end
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Compare on every falling edge.
  always @(negedge clk) begin
    cycles++;
    if (!done) begin
      check((exp_valid != 0) ? "R2" : exp_req, int'(out_valid), exp_valid, "valid");
      check(exp_req, int'(out_sink), exp_sink, "sink");
      check((exp_valid != 0) ? "R6" : exp_req, int'(out_two_word), exp_len, "length");
    end
    if (cycles > 20000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 20000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic send(input bit f, input int s, input int t, input bit w);
    @(negedge clk);
    in_valid = 1'b1; in_fwd = f; in_src = 3'(s); in_tag = 6'(t); in_write = w;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_fwd = 1'b0; in_src = '0; in_tag = '0; in_write = 1'b0;
  endtask

  // Direct check of a hand-computed result, sampled one cycle after the request.
  task automatic direct(input string req, input bit f, input int s, input int t,
                        input bit w, input int ev, input int es);
    send(f, s, t, w);
    idle();
    #1;
    check(req, int'(out_valid), ev, "direct valid");
    if (ev != 0) check(req, int'(out_sink), es, "direct sink");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", int'(out_valid), 0, "reset valid");
    check("R1", int'(out_sink), 0, "reset sink");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", int'(out_two_word), 0, "reset length");

    direct("R3", 1'b1, 0, 6'b000000, 1'b0, 1, 7);
    direct("R3", 1'b1, 0, 6'b000001, 1'b0, 1, 1);
    direct("R3", 1'b1, 3, 6'b001000, 1'b1, 1, 4);
    direct("R3", 1'b1, 3, 6'b000111, 1'b0, 1, 7);
    direct("R4", 1'b0, 7, 6'b000000, 1'b0, 1, 0);
    direct("R4", 1'b0, 7, 6'b100001, 1'b0, 1, 6);
    direct("R4", 1'b0, 2, 6'b000001, 1'b0, 1, 1);
    direct("R4", 1'b0, 4, 6'b111000, 1'b0, 1, 0);
    direct("R5", 1'b0, 1, 6'b111111, 1'b1, 1, 0);
    direct("R7", 1'b1, 7, 6'b000001, 1'b0, 0, 0);
    direct("R7", 1'b0, 0, 6'b100000, 1'b0, 0, 0);

    // Exhaustive sweep with idle gaps (R8) and alternating length marks (R6).
    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < 8; s++) begin
        for (int t = 0; t < 64; t++) begin
          send(d[0], s, t, t[0] ^ s[0]);
          if ((t % 7) == 3) idle();
        end
      end
    end
    idle();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule